// File: doc/BRIEF.md
# UART Debug Bus Bridge

This block lets a host reach a 32-bit memory-mapped bus through a serial byte link. Bytes arriving from a UART receiver are unstuffed, parsed into command frames, and turned into bus reads and writes. Read data, and the answer to an identity probe, are sent back as bytes to a UART transmitter. A further command pulses a reset line toward the target system.

Framing uses byte stuffing. The value 0x55 marks the start of a frame, and an unescaped 0x55 restarts parsing at any point. The value 0x5A is an escape prefix: inside a frame, the byte after it is always taken as plain data. Both byte links use valid/ready handshakes. The bus side is a request that is held until a one-cycle acknowledge.

Top module: `dbgb_bridge`

## Requirements
- R1: While rst_n is low and just after it is released, bus_req, tx_valid and tgt_rst are 0 and rx_ready is 1.
- R2: An unescaped receive byte 0x55 abandons any partly parsed frame, including a partly collected write word. The next byte is taken as a command.
- R3: Inside a frame, a receive byte 0x5A is dropped and the following byte is used literally, so address and data bytes of value 0x55 or 0x5A arrive as data.
- R4: A frame is 0x55, then a command byte. Commands 0x81, 0x82, 0x83 and 0x84 are followed by 4 address bytes and then 4 length bytes, each field least significant byte first. The length counts bytes and is rounded up to whole 32-bit words. A length of 0 issues no bus access.
- R5: For write commands, every 4 data bytes (least significant first) form one bus write. The address steps by 4 between words for 0x81 and stays fixed for 0x83.
- R6: For read commands, each word is fetched with a bus read and sent on tx least significant byte first. The address steps by 4 for 0x82 and stays fixed for 0x84.
- R7: Every transmitted byte equal to 0x55 or 0x5A is preceded by a 0x5A byte. No other byte is preceded this way.
- R8: Command 0x00 answers with the 32-bit parameter ID_WORD, least significant byte first, stuffed as in R7.
- R9: Command 0x80 sets tgt_rst high from the clock edge that accepts the command byte, for exactly RST_CYCLES cycles. No bus access is made.
- R10: An unknown command byte makes no bus access and sends nothing. Bytes that follow are ignored until the next 0x55.
- R11: bus_req stays high, with bus_addr, bus_we and bus_wdata stable, until bus_ack. Only one of bus_req and tx_valid is high at a time. rx_ready is low while either of them is high.
- R12: tx_valid stays high, with tx_data stable, until tx_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Bridge accepts the received byte this cycle |
| tx_valid | output | 1 | Byte to transmit present |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write access, 0 for a read |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | One-cycle completion of the access |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| tgt_rst | output | 1 | Reset pulse toward the target system |

## Verification
The bench builds the bridge with RST_CYCLES set to 6, so the reset pulse can be counted in full within a short run. ID_WORD is set to 0x125A5534, so the identity answer itself contains both special values and exercises transmit stuffing. Address and data width keep their 32-bit defaults. The bus model acknowledges after random delays and the transmit side stalls at random, which brings the request-hold and byte-hold rules into play on nearly every word.

// File: rtl/dbgb_pkg.sv
// Shared constants and types for the UART debug bus bridge.
// Assumes 8-bit link bytes; all codes here are fixed by the framing.
package dbgb_pkg;
    localparam logic [7:0] SYNC_B     = 8'h55;
    localparam logic [7:0] ESC_B      = 8'h5A;
    localparam logic [7:0] CMD_ID     = 8'h00;
    localparam logic [7:0] CMD_RST    = 8'h80;
    localparam logic [7:0] CMD_WR_INC = 8'h81;
    localparam logic [7:0] CMD_RD_INC = 8'h82;
    localparam logic [7:0] CMD_WR_FIX = 8'h83;
    localparam logic [7:0] CMD_RD_FIX = 8'h84;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_LEN, ST_WDATA, ST_BUS_WR, ST_BUS_RD, ST_TX
    } state_e;
endpackage

// File: rtl/dbgb_rx_unstuff.sv
// Receive-side unstuffer: marks sync bytes and strips escape prefixes.
// Assumes accept_en depends only on parser state, never on rx_valid.
// Escape prefixes are honoured only while a frame is open (in_frame).
module dbgb_rx_unstuff
    import dbgb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       accept_en,
    input  logic       in_frame,
    output logic       rx_ready,
    output logic       ev_valid,
    output logic       ev_sync,
    output logic [7:0] ev_data
);
    logic esc_q;
    logic fire;
    logic is_esc;

    // Classify the current byte against the escape state.
    always_comb begin
        fire     = rx_valid && accept_en;
        is_esc   = !esc_q && in_frame && (rx_data == ESC_B);
        rx_ready = accept_en;
        ev_valid = fire && !is_esc;
        ev_sync  = !esc_q && (rx_data == SYNC_B);
        ev_data  = rx_data;
    end

    // Remember that the previous accepted byte was an escape prefix.
    always_ff @(posedge clk) begin
        if (!rst_n)    esc_q <= 1'b0;
        else if (fire) esc_q <= is_esc;
    end
endmodule

// File: rtl/dbgb_tx_stuff.sv
// Transmit-side stuffer: inserts an escape byte before 0x55 or 0x5A.
// Assumes the producer holds in_data stable while in_valid is high.
module dbgb_tx_stuff
    import dbgb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready
);
    logic esc_sent_q;
    logic special;

    // Choose between the escape prefix and the payload byte.
    always_comb begin
        special  = (in_data == SYNC_B) || (in_data == ESC_B);
        tx_valid = in_valid;
        tx_data  = (special && !esc_sent_q) ? ESC_B : in_data;
        in_ready = tx_ready && (!special || esc_sent_q);
    end

    // Track whether the prefix for the current byte has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n)                    esc_sent_q <= 1'b0;
        else if (tx_valid && tx_ready) esc_sent_q <= special && !esc_sent_q;
    end
endmodule

// File: rtl/dbgb_ctrl.sv
// Frame parser and bus sequencer. Consumes unstuffed byte events, collects
// address, length and write words LSB first, runs bus accesses and feeds
// response bytes to the stuffer. Assumes ADDR_W, DATA_W, LEN_W are multiples of 8.
module dbgb_ctrl
    import dbgb_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              DATA_W     = 32,
    parameter int              LEN_W      = 32,
    parameter logic [DATA_W-1:0] ID_WORD  = 32'hD0B6_0001,
    parameter int              RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_sync,
    input  logic [7:0]        ev_data,
    output logic              accept_en,
    output logic              in_frame,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    input  logic              byte_ready,
    output logic              tgt_rst
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int LEN_BYTES  = LEN_W / 8;
    localparam int BYTES      = DATA_W / 8;
    localparam int MAXB       = (ADDR_BYTES > BYTES) ? ((ADDR_BYTES > LEN_BYTES) ? ADDR_BYTES : LEN_BYTES)
                                                     : ((BYTES > LEN_BYTES) ? BYTES : LEN_BYTES);
    localparam int CNT_W      = $clog2(MAXB + 1);
    localparam int RST_W      = $clog2(RST_CYCLES + 1);

    state_e             state_q;
    logic [CNT_W-1:0]   bidx_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   len_q;
    logic [DATA_W-1:0]  shift_q;
    logic               we_q;
    logic               inc_q;
    logic [RST_W-1:0]   rst_cnt_q;

    logic               data_ev;
    logic [LEN_W-1:0]   len_nx;
    logic [LEN_W-1:0]   len_dec;
    logic [ADDR_W-1:0]  addr_nx;
    logic               rst_fire;

    // Derived next values and outward decode of the state.
    always_comb begin
        data_ev    = ev_valid && !ev_sync;
        len_nx     = {ev_data, len_q[LEN_W-1:8]};
        len_dec    = (len_q > LEN_W'(BYTES)) ? (len_q - LEN_W'(BYTES)) : '0;
        addr_nx    = inc_q ? (addr_q + ADDR_W'(BYTES)) : addr_q;
        rst_fire   = (state_q == ST_CMD) && data_ev && (ev_data == CMD_RST);
        accept_en  = (state_q == ST_IDLE) || (state_q == ST_CMD) || (state_q == ST_ADDR)
                  || (state_q == ST_LEN)  || (state_q == ST_WDATA);
        in_frame   = (state_q != ST_IDLE);
        bus_req    = (state_q == ST_BUS_WR) || (state_q == ST_BUS_RD);
        bus_we     = (state_q == ST_BUS_WR);
        bus_addr   = addr_q;
        bus_wdata  = shift_q;
        byte_valid = (state_q == ST_TX);
        byte_data  = shift_q[7:0];
        tgt_rst    = (rst_cnt_q != '0);
    end

    // Main frame sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bidx_q  <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            shift_q <= '0;
            we_q    <= 1'b0;
            inc_q   <= 1'b0;
        end else if (ev_valid && ev_sync) begin
            state_q <= ST_CMD;
            bidx_q  <= '0;
        end else begin
            case (state_q)
                ST_CMD: if (data_ev) begin
                    bidx_q <= '0;
                    case (ev_data)
                        CMD_ID: begin
                            shift_q <= ID_WORD;
                            len_q   <= '0;
                            state_q <= ST_TX;
                        end
                        CMD_WR_INC, CMD_RD_INC, CMD_WR_FIX, CMD_RD_FIX: begin
                            we_q    <= (ev_data == CMD_WR_INC) || (ev_data == CMD_WR_FIX);
                            inc_q   <= (ev_data == CMD_WR_INC) || (ev_data == CMD_RD_INC);
                            state_q <= ST_ADDR;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
                ST_ADDR: if (data_ev) begin
                    addr_q <= {ev_data, addr_q[ADDR_W-1:8]};
                    if (bidx_q == CNT_W'(ADDR_BYTES - 1)) begin
                        bidx_q  <= '0;
                        state_q <= ST_LEN;
                    end else bidx_q <= bidx_q + 1'b1;
                end
                ST_LEN: if (data_ev) begin
                    len_q <= len_nx;
                    if (bidx_q == CNT_W'(LEN_BYTES - 1)) begin
                        bidx_q  <= '0;
                        state_q <= (len_nx == '0) ? ST_IDLE : (we_q ? ST_WDATA : ST_BUS_RD);
                    end else bidx_q <= bidx_q + 1'b1;
                end
                ST_WDATA: if (data_ev) begin
                    shift_q <= {ev_data, shift_q[DATA_W-1:8]};
                    if (bidx_q == CNT_W'(BYTES - 1)) begin
                        bidx_q  <= '0;
                        state_q <= ST_BUS_WR;
                    end else bidx_q <= bidx_q + 1'b1;
                end
                ST_BUS_WR: if (bus_ack) begin
                    addr_q  <= addr_nx;
                    len_q   <= len_dec;
                    state_q <= (len_dec == '0) ? ST_IDLE : ST_WDATA;
                end
                ST_BUS_RD: if (bus_ack) begin
                    shift_q <= bus_rdata;
                    addr_q  <= addr_nx;
                    len_q   <= len_dec;
                    bidx_q  <= '0;
                    state_q <= ST_TX;
                end
                ST_TX: if (byte_ready) begin
                    shift_q <= {8'h00, shift_q[DATA_W-1:8]};
                    if (bidx_q == CNT_W'(BYTES - 1)) begin
                        bidx_q  <= '0;
                        state_q <= (len_q == '0) ? ST_IDLE : ST_BUS_RD;
                    end else bidx_q <= bidx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Target reset pulse counter, reloaded by each reset command.
    always_ff @(posedge clk) begin
        if (!rst_n)               rst_cnt_q <= '0;
        else if (rst_fire)        rst_cnt_q <= RST_W'(RST_CYCLES);
        else if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - 1'b1;
    end
endmodule

// File: rtl/dbgb_bridge.sv
// Top of the UART debug bus bridge: unstuffer, parser/sequencer, stuffer.
// Assumes a single clock domain and a bus slave that acknowledges every request.
module dbgb_bridge #(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                LEN_W      = 32,
    parameter logic [DATA_W-1:0] ID_WORD    = 32'hD0B6_0001,
    parameter int                RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              tgt_rst
);
    logic       accept_en, in_frame;
    logic       ev_valid, ev_sync;
    logic [7:0] ev_data;
    logic       byte_valid, byte_ready;
    logic [7:0] byte_data;

    dbgb_rx_unstuff u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .accept_en(accept_en), .in_frame(in_frame), .rx_ready(rx_ready),
        .ev_valid(ev_valid), .ev_sync(ev_sync), .ev_data(ev_data)
    );

    dbgb_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
        .ID_WORD(ID_WORD), .RST_CYCLES(RST_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_sync(ev_sync), .ev_data(ev_data),
        .accept_en(accept_en), .in_frame(in_frame),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .tgt_rst(tgt_rst)
    );

    dbgb_tx_stuff u_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(byte_valid), .in_data(byte_data),
        .in_ready(byte_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );
endmodule

// File: rtl/dbgb_bridge_chk.sv
// Protocol checker for dbgb_bridge, attached by bind. Watches handshakes,
// transmit stuffing and the width of the target reset pulse.
module dbgb_bridge_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int RST_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              tgt_rst
);
    logic [31:0] run_q;
    logic        esc_open_q;

    // Length of the current high run of tgt_rst.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (tgt_rst) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    // Set after a transmitted escape prefix, cleared by the byte it guards.
    always_ff @(posedge clk) begin
        if (!rst_n) esc_open_q <= 1'b0;
        else if (tx_valid && tx_ready) esc_open_q <= !esc_open_q && (tx_data == 8'h5A);
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R11
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && tx_valid)); // R11
    AST_RX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || tx_valid) |-> !rx_ready); // R11
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R12
    AST_ESC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && esc_open_q |-> (tx_data == 8'h55) || (tx_data == 8'h5A)); // R7
    AST_NO_BARE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !esc_open_q |-> tx_data != 8'h55); // R7
    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_rst) |-> run_q >= 32'(RST_CYCLES)); // R9
endmodule

bind dbgb_bridge dbgb_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .tgt_rst(tgt_rst)
);

// File: tb/dbgb_bridge_tb_top.sv
module dbgb_bridge_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          RST_CYC    = 6;
    localparam logic [31:0] ID_VAL     = 32'h125A_5534;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        tgt_rst;

    dbgb_bridge #(.ID_WORD(ID_VAL), .RST_CYCLES(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .tgt_rst(tgt_rst)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [0:63];
    logic [31:0] wa [0:255], wd [0:255], ra [0:255], wexp [0:255];
    logic [7:0]  txq [0:1023], ex [0:1023];
    int wn = 0, rn = 0, tn = 0, en = 0, rstlen = 0, dly = -1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bus slave model: random acknowledge delay, logs every access.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0; dly = -1;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (dly < 0) dly = int'($urandom % 4);
            if (dly == 0) begin
                bus_ack = 1'b1;
                if (bus_we) begin wa[wn] = bus_addr; wd[wn] = bus_wdata; wn++; end
                else begin bus_rdata = mem[bus_addr[7:2]]; ra[rn] = bus_addr; rn++; end
                dly = -1;
            end else dly--;
        end
    end

    // Transmit sink with random stalls.
    always @(negedge clk) begin
        tx_ready = rst_n && (($urandom % 4) != 0);
        #1;
        if (tx_valid && tx_ready) begin txq[tn] = tx_data; tn++; end
    end

    // Count cycles with the target reset high.
    always @(negedge clk) if (tgt_rst) rstlen++;

    task automatic send_raw(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        #1;
        while (!rx_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    task automatic send_d(input logic [7:0] b);
        if (b == 8'h55 || b == 8'h5A) send_raw(8'h5A);
        send_raw(b);
    endtask

    task automatic send_w32(input logic [31:0] w);
        for (int i = 0; i < 4; i++) send_d(w[8*i +: 8]);
    endtask

    task automatic frame(input logic [7:0] cmd, input logic [31:0] a, input logic [31:0] l);
        send_raw(8'h55); send_raw(cmd); send_w32(a); send_w32(l);
    endtask

    task automatic settle();
        int q = 0;
        while (q < 4) begin
            @(negedge clk); #2;
            if (rx_ready && !tx_valid && !bus_req) q++; else q = 0;
        end
    endtask

    task automatic clr();
        wn = 0; rn = 0; tn = 0; en = 0;
    endtask

    task automatic exp_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) begin
            if (w[8*i +: 8] == 8'h55 || w[8*i +: 8] == 8'h5A) begin ex[en] = 8'h5A; en++; end
            ex[en] = w[8*i +: 8]; en++;
        end
    endtask

    task automatic chk_tx(input string tag);
        chk(tn == en, {tag, " tx count"}, 32'(tn), 32'(en));
        for (int i = 0; i < en && i < tn; i++) chk(txq[i] == ex[i], {tag, " tx byte"}, 32'(txq[i]), 32'(ex[i]));
    endtask

    task automatic chk_writes(input string tag, input logic [31:0] a0, input bit inc, input int n);
        chk(wn == n, {tag, " write count"}, 32'(wn), 32'(n));
        for (int i = 0; i < n && i < wn; i++) begin
            chk(wa[i] == (inc ? a0 + 32'(4*i) : a0), {tag, " write addr"}, wa[i], inc ? a0 + 32'(4*i) : a0);
            chk(wd[i] == wexp[i], {tag, " write data"}, wd[i], wexp[i]);
        end
    endtask

    task automatic do_write(input string tag, input bit inc, input logic [31:0] a0, input int words);
        clr();
        frame(inc ? 8'h81 : 8'h83, a0, 32'(4*words));
        for (int i = 0; i < words; i++) send_w32(wexp[i]);
        settle();
        chk_writes(tag, a0, inc, words);
    endtask

    task automatic do_read(input string tag, input bit inc, input logic [31:0] a0, input int words);
        clr();
        frame(inc ? 8'h82 : 8'h84, a0, 32'(4*words));
        settle();
        chk(rn == words, {tag, " read count"}, 32'(rn), 32'(words));
        for (int i = 0; i < words; i++) begin
            logic [31:0] ea = inc ? a0 + 32'(4*i) : a0;
            if (i < rn) chk(ra[i] == ea, {tag, " read addr"}, ra[i], ea);
            exp_word(mem[ea[7:2]]);
        end
        chk_tx(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mem[i] = (32'(i) * 32'h0103_0507) ^ 32'hC3A0_0000;
        mem[8] = 32'h5A01_55AA;
        mem[9] = 32'h5555_5A5A;
        repeat (4) @(negedge clk);
        // R1: reset state, checked during and after reset
        chk(!bus_req && !tx_valid && !tgt_rst, "R1 outputs in reset", {29'd0, bus_req, tx_valid, tgt_rst}, 0);
        @(negedge clk); rst_n = 1'b1; #1;
        chk(rx_ready && !bus_req && !tx_valid && !tgt_rst, "R1 after reset",
            {28'd0, rx_ready, bus_req, tx_valid, tgt_rst}, 32'h8);

        // R8: identity probe, with stuffed bytes inside the identifier
        clr();
        send_raw(8'h55); send_raw(8'h00);
        settle();
        exp_word(ID_VAL);
        chk_tx("R8 identity");
        chk(wn == 0 && rn == 0, "R8 no bus access", 32'(wn + rn), 0);

        // R5 R3: incrementing write, data with special bytes
        wexp[0] = 32'h1122_5533; wexp[1] = 32'h5A5A_0000; wexp[2] = 32'hDEAD_BEEF;
        do_write("R5 R3 write inc", 1'b1, 32'h0000_0010, 3);

        // R5: fixed-address write
        wexp[0] = 32'h0BAD_F00D; wexp[1] = 32'h0000_0055;
        do_write("R5 write fixed", 1'b0, 32'h0000_0200, 2);

        // R3: address bytes that need escaping
        wexp[0] = 32'h5555_5A5A;
        do_write("R3 escaped addr", 1'b1, 32'h005A_5510, 1);

        // R6 R7: reads with stuffed response bytes
        do_read("R6 R7 read inc", 1'b1, 32'h0000_0020, 3);
        do_read("R6 read fixed", 1'b0, 32'h0000_0024, 2);

        // R4: length not a multiple of 4 rounds up to whole words
        clr();
        wexp[0] = 32'h0102_0304; wexp[1] = 32'hA0B0_C0D0;
        frame(8'h81, 32'h0000_0300, 32'd5);
        send_w32(wexp[0]); send_w32(wexp[1]);
        settle();
        chk_writes("R4 length 5", 32'h0000_0300, 1'b1, 2);

        // R4: zero length makes no access
        clr();
        frame(8'h82, 32'h0000_0040, 32'd0);
        frame(8'h81, 32'h0000_0044, 32'd0);
        settle();
        chk(wn == 0 && rn == 0 && tn == 0, "R4 zero length", 32'(wn + rn + tn), 0);

        // R2: sync aborts a partial address field
        clr();
        send_raw(8'h55); send_raw(8'h81); send_d(8'h10); send_d(8'h20);
        wexp[0] = 32'hCAFE_0001;
        frame(8'h83, 32'h0000_0040, 32'd4);
        send_w32(wexp[0]);
        settle();
        chk_writes("R2 abort in addr", 32'h0000_0040, 1'b0, 1);

        // R2: sync discards a half-collected write word
        clr();
        frame(8'h81, 32'h0000_0080, 32'd8);
        send_w32(32'hAABB_CCDD);
        send_d(8'h77); send_d(8'h66);
        frame(8'h81, 32'h0000_0090, 32'd4);
        send_w32(32'h0102_0304);
        settle();
        chk(wn == 2, "R2 abort in data count", 32'(wn), 2);
        chk(wa[0] == 32'h80 && wd[0] == 32'hAABB_CCDD, "R2 first word", wd[0], 32'hAABB_CCDD);
        chk(wa[1] == 32'h90 && wd[1] == 32'h0102_0304, "R2 new frame word", wd[1], 32'h0102_0304);

        // R10: unknown command, then a would-be frame without sync
        clr();
        send_raw(8'h55); send_raw(8'h7E);
        send_raw(8'h81); send_w32(32'h0000_0010); send_w32(32'd4); send_w32(32'h1234_5678);
        send_raw(8'h82); send_w32(32'h0000_0020); send_w32(32'd4);
        settle();
        chk(wn == 0 && rn == 0 && tn == 0, "R10 ignored bytes", 32'(wn + rn + tn), 0);
        wexp[0] = 32'h7777_8888;
        do_write("R10 recovery", 1'b1, 32'h0000_0060, 1);

        // R9: target reset pulse width
        clr();
        rstlen = 0;
        send_raw(8'h55); send_raw(8'h80);
        repeat (RST_CYC + 4) @(negedge clk);
        chk(rstlen == RST_CYC, "R9 reset width", 32'(rstlen), 32'(RST_CYC));
        chk(!tgt_rst, "R9 reset released", {31'd0, tgt_rst}, 0);
        chk(wn == 0 && rn == 0, "R9 no bus access", 32'(wn + rn), 0);

        // R5 R3 R11: random write frames
        for (int k = 0; k < 10; k++) begin
            bit inc = bit'($urandom % 2);
            int words = 1 + int'($urandom % 4);
            logic [31:0] a0 = $urandom & 32'hFFFF_FFFC;
            for (int i = 0; i < words; i++) begin
                wexp[i] = $urandom;
                if ((k + i) % 3 == 0) wexp[i][15:8] = 8'h55;
                if ((k + i) % 3 == 1) wexp[i][7:0]  = 8'h5A;
            end
            do_write("R5 R3 random write", inc, a0, words);
        end

        // R6 R7 R12: random read frames
        for (int k = 0; k < 6; k++) begin
            bit inc = bit'($urandom % 2);
            int words = 1 + int'($urandom % 4);
            logic [31:0] a0 = {24'd0, 8'($urandom) & 8'hC0} + 32'h10;
            do_read("R6 R7 random read", inc, a0, words);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule